// File: doc/BRIEF.md
# SDRAM Command Controller

This block turns single-word memory requests into the command stream of a four-bank, single-data-rate SDRAM with a 16-bit data bus. A request carries a flat word address, a read/write flag and, for writes, one data word. The controller accepts it with a ready/valid handshake. It opens the addressed row and performs the one-word access with auto precharge. For reads it returns the word on a one-cycle valid strobe once the programmed CAS latency has passed.

After reset the controller waits through a power-up delay with NOPs. It then precharges all banks, issues two auto refreshes and loads the mode register. The mode word selects burst length one, sequential order and the CAS latency parameter. A free-running interval timer raises a refresh request about every 64 ms / 4096. That request is served at the next idle point, ahead of any waiting user request. Every spacing between commands is a clock count set by a parameter.

The machine has these states:
- ST_PWRUP counts down the power-up delay.
- ST_PRE_ALL, ST_INIT_REF and ST_LOAD_MODE make up the start-up sequence.
- ST_IDLE arbitrates between refresh and requests.
- ST_AUTO_REF, ST_ACTIVATE and ST_ACCESS each issue one command.
- ST_WAIT holds NOPs for the required gap and then returns to the state stored in a return register.

The transitions are:
- ST_PWRUP→ST_PRE_ALL
- ST_PRE_ALL→ST_WAIT→ST_INIT_REF
- ST_INIT_REF→ST_WAIT→ST_INIT_REF (first pass) or →ST_LOAD_MODE (second pass)
- ST_LOAD_MODE→ST_WAIT→ST_IDLE
- ST_IDLE→ST_AUTO_REF (refresh pending) or →ST_ACTIVATE (request taken)
- ST_AUTO_REF→ST_WAIT→ST_IDLE
- ST_ACTIVATE→ST_WAIT→ST_ACCESS
- ST_ACCESS→ST_WAIT→ST_IDLE

Top module: `sdram_cmd_ctrl`

## Requirements
- R1: While reset is asserted and through the power-up wait, the command pins carry NOP (chip select low, row strobe, column strobe and write enable high), clock enable is high, req_ready and rd_valid are low and the data driver is off.
- R2: The first command other than NOP is a PRECHARGE with sd_addr[10] high (all banks), registered exactly POWERUP_CYC cycles after reset is released.
- R3: The start-up order is PRECHARGE-all, AUTO REFRESH, AUTO REFRESH, LOAD MODE, spaced T_RP, T_RFC and T_RFC cycles apart. The mode word is placed on sd_addr with bank 0. Its bits 6:4 hold CAS_LAT, bits 2:0 hold 0 (burst of one), bit 3 holds 0 (sequential) and all other bits are zero.
- R4: Commands are encoded on {cs_n, ras_n, cas_n, we_n} as follows: LOAD MODE 0000, AUTO REFRESH 0001, PRECHARGE 0010, ACTIVE 0011, WRITE 0100, READ 0101, NOP 0111.
- R5: req_ready is high only when the controller is idle with no refresh pending. A request is taken on a clock edge where req_valid and req_ready are both high. The request address is split as bank = req_addr[21:20], row = req_addr[19:8] and column = req_addr[7:0].
- R6: A taken request is followed on the next cycle by ACTIVE, with the bank on sd_ba and the row on sd_addr. READ or WRITE follows no sooner than T_RCD cycles later, with the column on sd_addr[7:0] and sd_addr[10] high (auto precharge).
- R7: Write data is driven on sd_dq_out with sd_dq_oe high in the WRITE cycle and in no other cycle. sd_dqm stays 0.
- R8: No command follows a WRITE sooner than T_WR + T_RP cycles later, and none follows a READ sooner than CAS_LAT + T_RP cycles later. A bank is therefore closed and recovered before it is activated again.
- R9: Read data is sampled from sd_dq_in CAS_LAT clock edges after the READ is registered. It is presented on rd_data with rd_valid high for exactly one cycle, 1 + T_RCD + CAS_LAT edges after the request was taken. This holds for CAS_LAT of 2 and of 3.
- R10: An AUTO REFRESH is issued once per REF_CYC cycles after start-up, never later than a short access time past its due point. A pending refresh wins over a waiting request. No command follows an AUTO REFRESH sooner than T_RFC cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 22 | Word address {bank, row, column} |
| req_wdata | input | 16 | Write data |
| req_ready | output | 1 | Request can be taken this cycle |
| rd_valid | output | 1 | Read data strobe |
| rd_data | output | 16 | Read data |
| sd_cke | output | 1 | SDRAM clock enable |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank select |
| sd_addr | output | 12 | Row / column / mode address |
| sd_dqm | output | 2 | Byte masks, held 0 |
| sd_dq_out | output | 16 | Data to the SDRAM |
| sd_dq_oe | output | 1 | Enable for the data driver |
| sd_dq_in | input | 16 | Data from the SDRAM |

## Verification
A corrupted state register or return register shows up at the SDRAM pins within one or two cycles. Examples are an unexpected command, a READ to a closed bank, or a start-up step out of order, and the bus model in the bench flags each at the edge where it is registered. A wrong gap count shows as a command arriving before its recovery time, or, when the gap is too long, as a shifted start-up or read-return cycle. A broken CAS-latency pipeline returns the model's filler word instead of the stored data. A refresh starved by a stream of requests exceeds the refresh interval limit within one interval.

// File: rtl/sdr_ctrl_pkg.sv
package sdr_ctrl_pkg;

    // {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_LMR = 4'b0000,
        CMD_REF = 4'b0001,
        CMD_PRE = 4'b0010,
        CMD_ACT = 4'b0011,
        CMD_WR  = 4'b0100,
        CMD_RD  = 4'b0101,
        CMD_NOP = 4'b0111
    } sdr_cmd_e;

    typedef enum logic [3:0] {
        ST_PWRUP,
        ST_PRE_ALL,
        ST_INIT_REF,
        ST_LOAD_MODE,
        ST_IDLE,
        ST_AUTO_REF,
        ST_ACTIVATE,
        ST_ACCESS,
        ST_WAIT
    } ctrl_state_e;

endpackage

// File: rtl/sdr_ref_timer.sv
module sdr_ref_timer #(
    parameter int REF_CYC = 2080
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic served,
    output logic pend
);
    localparam int CW = $clog2(REF_CYC + 1);

    logic [CW-1:0] cnt;
    logic          tick;

    assign tick = run && (cnt == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= CW'(REF_CYC - 1);
            pend <= 1'b0;
        end else begin
            if (run) cnt <= (cnt == '0) ? CW'(REF_CYC - 1) : cnt - 1'b1;
            pend <= tick | (pend & ~served);
        end
    end

    // R10
    tick_sets_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> pend);

    // R10
    pend_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !served) |=> pend);

endmodule

// File: rtl/sdr_rd_capture.sv
module sdr_rd_capture #(
    parameter int DATA_W  = 16,
    parameter int CAS_LAT = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_rd,
    input  logic [DATA_W-1:0] dq_in,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);
    logic [CAS_LAT-1:0] pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe     <= '0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            pipe     <= {pipe[CAS_LAT-2:0], issue_rd};
            rd_valid <= pipe[CAS_LAT-1];
            if (pipe[CAS_LAT-1]) rd_data <= dq_in;
        end
    end

    // R9
    rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(issue_rd, CAS_LAT + 1));

    // R9
    rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

endmodule

// File: rtl/sdram_cmd_ctrl.sv
module sdram_cmd_ctrl
    import sdr_ctrl_pkg::*;
#(
    parameter int BANK_W      = 2,
    parameter int ROW_W       = 12,
    parameter int COL_W       = 8,
    parameter int DATA_W      = 16,
    parameter int CAS_LAT     = 3,
    parameter int POWERUP_CYC = 13300,
    parameter int T_RCD       = 3,
    parameter int T_RP        = 3,
    parameter int T_RFC       = 9,
    parameter int T_MRD       = 2,
    parameter int T_WR        = 2,
    parameter int REF_CYC     = 2080
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            req_valid,
    input  logic                            req_we,
    input  logic [BANK_W+ROW_W+COL_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]               req_wdata,
    output logic                            req_ready,
    output logic                            rd_valid,
    output logic [DATA_W-1:0]               rd_data,
    output logic                            sd_cke,
    output logic                            sd_cs_n,
    output logic                            sd_ras_n,
    output logic                            sd_cas_n,
    output logic                            sd_we_n,
    output logic [BANK_W-1:0]               sd_ba,
    output logic [ROW_W-1:0]                sd_addr,
    output logic [DATA_W/8-1:0]             sd_dqm,
    output logic [DATA_W-1:0]               sd_dq_out,
    output logic                            sd_dq_oe,
    input  logic [DATA_W-1:0]               sd_dq_in
);
    localparam int ADDR_W = BANK_W + ROW_W + COL_W;
    localparam int CNT_W  = $clog2(POWERUP_CYC + T_RFC + T_WR + T_RP + CAS_LAT + 2);
    localparam int AP_BIT = 10;
    localparam logic [ROW_W-1:0] MODE_WORD = ROW_W'(CAS_LAT << 4);

    ctrl_state_e        state, ret_state;
    logic [CNT_W-1:0]   cnt;
    logic               init_second, init_done;
    logic               lat_we;
    logic [BANK_W-1:0]  lat_bank;
    logic [ROW_W-1:0]   lat_row;
    logic [COL_W-1:0]   lat_col;
    logic [DATA_W-1:0]  lat_wdata;
    logic               ref_pend, issue_rd;
    sdr_cmd_e           cmd;

    assign req_ready = (state == ST_IDLE) && !ref_pend;
    assign issue_rd  = (state == ST_ACCESS) && !lat_we;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state       <= ST_PWRUP;
            ret_state   <= ST_IDLE;
            cnt         <= CNT_W'(POWERUP_CYC);
            init_second <= 1'b0;
            init_done   <= 1'b0;
            lat_we      <= 1'b0;
            lat_bank    <= '0;
            lat_row     <= '0;
            lat_col     <= '0;
            lat_wdata   <= '0;
        end else begin
            unique case (state)
                ST_PWRUP: begin
                    if (cnt == CNT_W'(1)) state <= ST_PRE_ALL;
                    else                  cnt   <= cnt - 1'b1;
                end
                ST_PRE_ALL: begin
                    state     <= ST_WAIT;
                    cnt       <= CNT_W'(T_RP - 1);
                    ret_state <= ST_INIT_REF;
                end
                ST_INIT_REF: begin
                    state       <= ST_WAIT;
                    cnt         <= CNT_W'(T_RFC - 1);
                    ret_state   <= init_second ? ST_LOAD_MODE : ST_INIT_REF;
                    init_second <= 1'b1;
                end
                ST_LOAD_MODE: begin
                    state     <= ST_WAIT;
                    cnt       <= CNT_W'(T_MRD - 1);
                    ret_state <= ST_IDLE;
                    init_done <= 1'b1;
                end
                ST_IDLE: begin
                    if (ref_pend) begin
                        state <= ST_AUTO_REF;
                    end else if (req_valid) begin
                        state     <= ST_ACTIVATE;
                        lat_we    <= req_we;
                        lat_bank  <= req_addr[ADDR_W-1 -: BANK_W];
                        lat_row   <= req_addr[COL_W +: ROW_W];
                        lat_col   <= req_addr[COL_W-1:0];
                        lat_wdata <= req_wdata;
                    end
                end
                ST_AUTO_REF: begin
                    state     <= ST_WAIT;
                    cnt       <= CNT_W'(T_RFC - 1);
                    ret_state <= ST_IDLE;
                end
                ST_ACTIVATE: begin
                    state     <= ST_WAIT;
                    cnt       <= CNT_W'(T_RCD - 1);
                    ret_state <= ST_ACCESS;
                end
                ST_ACCESS: begin
                    state     <= ST_WAIT;
                    cnt       <= lat_we ? CNT_W'(T_WR + T_RP - 1) : CNT_W'(CAS_LAT + T_RP - 1);
                    ret_state <= ST_IDLE;
                end
                ST_WAIT: begin
                    if (cnt == CNT_W'(1)) state <= ret_state;
                    else                  cnt   <= cnt - 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        cmd       = CMD_NOP;
        sd_ba     = '0;
        sd_addr   = '0;
        sd_dq_oe  = 1'b0;
        unique case (state)
            ST_PRE_ALL: begin
                cmd             = CMD_PRE;
                sd_addr[AP_BIT] = 1'b1;
            end
            ST_INIT_REF, ST_AUTO_REF: cmd = CMD_REF;
            ST_LOAD_MODE: begin
                cmd     = CMD_LMR;
                sd_addr = MODE_WORD;
            end
            ST_ACTIVATE: begin
                cmd     = CMD_ACT;
                sd_ba   = lat_bank;
                sd_addr = lat_row;
            end
            ST_ACCESS: begin
                cmd             = lat_we ? CMD_WR : CMD_RD;
                sd_ba           = lat_bank;
                sd_addr         = ROW_W'(lat_col);
                sd_addr[AP_BIT] = 1'b1;
                sd_dq_oe        = lat_we;
            end
            default: cmd = CMD_NOP;
        endcase
    end

    assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;
    assign sd_cke    = 1'b1;
    assign sd_dqm    = '0;
    assign sd_dq_out = lat_wdata;

    sdr_ref_timer #(.REF_CYC(REF_CYC)) u_ref (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (init_done),
        .served (state == ST_AUTO_REF),
        .pend   (ref_pend)
    );

    sdr_rd_capture #(.DATA_W(DATA_W), .CAS_LAT(CAS_LAT)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .issue_rd (issue_rd),
        .dq_in    (sd_dq_in),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

    // R10
    ref_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && ref_pend) |=> (cmd == CMD_REF));

    // R6
    take_then_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (cmd == CMD_ACT));

    // R6
    act_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_ACT) |=> (cmd == CMD_NOP));

    // R8
    wr_recover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_WR) |=> (cmd == CMD_NOP && !sd_dq_oe));

    // R3
    single_mode_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_LMR) |-> !init_done);

endmodule

// File: tb/sim_sdram_cmd_ctrl.sv
module sdr_bus_model #(
    parameter int CL      = 2,
    parameter int PWR     = 40,
    parameter int T_RCD   = 2,
    parameter int T_RP    = 2,
    parameter int T_RFC   = 6,
    parameter int T_MRD   = 2,
    parameter int T_WR    = 2,
    parameter int REF_CYC = 150,
    parameter int SLACK   = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cs_n,
    input  logic        ras_n,
    input  logic        cas_n,
    input  logic        we_n,
    input  logic [1:0]  ba,
    input  logic [11:0] a,
    input  logic [15:0] dq_out,
    input  logic        dq_oe,
    output logic [15:0] dq_in,
    output int          errs,
    output int          refs,
    output int          init_at
);
    logic [15:0] mem [int];
    int   cyc, step, busy, last_ref, act_at [4], rdy_at [4];
    logic open_b [4];
    logic [11:0] row_b [4];
    logic pv [4];
    logic [15:0] pd [4];

    assign dq_in = pv[CL-1] ? pd[CL-1] : 16'hDEAD;

    task automatic bad(input string r, input string m, input int act, input int exp);
        errs++;
        $display("FAIL %s bus model: %s at cycle %0d, actual %0d expected %0d", r, m, cyc, act, exp);
    endtask

    always @(posedge clk) begin
        logic [3:0] c;
        int key;
        if (!rst_n) begin
            cyc = 0; step = 0; busy = 0; last_ref = -1;
            errs = 0; refs = 0; init_at = -1;
            for (int i = 0; i < 4; i++) begin
                open_b[i] = 1'b0; rdy_at[i] = 0; act_at[i] = 0; row_b[i] = '0;
                pv[i] <= 1'b0; pd[i] <= '0;
            end
        end else begin
            c = {cs_n, ras_n, cas_n, we_n};
            for (int i = 3; i > 0; i--) begin pv[i] <= pv[i-1]; pd[i] <= pd[i-1]; end
            pv[0] <= 1'b0;
            if (dq_oe && c != 4'b0100) bad("R7", "data driver on outside WRITE", 1, 0);
            if (!cs_n && c != 4'b0111) begin
                if (cyc < busy) bad("R8", "command inside recovery gap", cyc, busy);
                if (step < 4) begin
                    case (step)
                        0: begin
                            if (c != 4'b0010 || !a[10]) bad("R3", "expected PRECHARGE all", int'(c), 2);
                            if (cyc != PWR) bad("R2", "PRECHARGE cycle", cyc, PWR);
                            busy = cyc + T_RP;
                        end
                        1, 2: begin
                            if (c != 4'b0001) bad("R3", "expected AUTO REFRESH", int'(c), 1);
                            busy = cyc + T_RFC;
                        end
                        default: begin
                            if (c != 4'b0000) bad("R3", "expected LOAD MODE", int'(c), 0);
                            if (a != 12'(CL << 4) || ba != 2'd0) bad("R3", "mode word", int'(a), CL << 4);
                            busy = cyc + T_MRD;
                            init_at = cyc;
                        end
                    endcase
                    step++;
                end else begin
                    case (c)
                        4'b0011: begin
                            if (open_b[ba]) bad("R8", "ACTIVE to open bank", 1, 0);
                            if (cyc < rdy_at[ba]) bad("R8", "ACTIVE before bank recovered", cyc, rdy_at[ba]);
                            open_b[ba] = 1'b1; row_b[ba] = a; act_at[ba] = cyc;
                        end
                        4'b0100, 4'b0101: begin
                            if (!open_b[ba]) bad("R6", "access to closed bank", 0, 1);
                            if (cyc - act_at[ba] < T_RCD) bad("R6", "ACTIVE to access gap", cyc - act_at[ba], T_RCD);
                            if (!a[10]) bad("R6", "auto precharge bit", 0, 1);
                            key = int'({ba, row_b[ba], a[7:0]});
                            if (c == 4'b0100) begin
                                if (!dq_oe) bad("R7", "data driver off in WRITE", 0, 1);
                                mem[key] = dq_out;
                                rdy_at[ba] = cyc + T_WR + T_RP;
                            end else begin
                                pv[0] <= 1'b1;
                                pd[0] <= mem.exists(key) ? mem[key] : 16'h0000;
                                rdy_at[ba] = cyc + 1 + T_RP;
                            end
                            open_b[ba] = 1'b0;
                        end
                        4'b0001: begin
                            for (int i = 0; i < 4; i++)
                                if (open_b[i] || cyc < rdy_at[i]) bad("R10", "REFRESH with bank busy", i, -1);
                            if (last_ref >= 0 && cyc - last_ref > REF_CYC + SLACK)
                                bad("R10", "refresh interval", cyc - last_ref, REF_CYC);
                            last_ref = cyc;
                            refs++;
                            busy = cyc + T_RFC;
                        end
                        default: bad("R4", "unexpected command after start-up", int'(c), 7);
                    endcase
                end
            end
            cyc++;
        end
    end
endmodule

module sim_sdram_cmd_ctrl;
    localparam int PWR = 40, T_RCD = 2, T_RP = 2, T_RFC = 6, T_MRD = 2, T_WR = 2, REF_CYC = 150;
    localparam int NV = 13;
    // {we, bank, row, col, data}
    localparam logic [38:0] VECS [NV] = '{
        {1'b1, 2'd0, 12'h001, 8'h05, 16'h1234},
        {1'b1, 2'd3, 12'hFFF, 8'hFF, 16'hBEEF},
        {1'b1, 2'd1, 12'h123, 8'h00, 16'h0F0F},
        {1'b1, 2'd0, 12'h002, 8'h05, 16'h5555},
        {1'b1, 2'd2, 12'h400, 8'h80, 16'hA5A5},
        {1'b0, 2'd0, 12'h001, 8'h05, 16'h0000},
        {1'b0, 2'd3, 12'hFFF, 8'hFF, 16'h0000},
        {1'b0, 2'd1, 12'h123, 8'h00, 16'h0000},
        {1'b0, 2'd0, 12'h002, 8'h05, 16'h0000},
        {1'b0, 2'd2, 12'h400, 8'h80, 16'h0000},
        {1'b0, 2'd2, 12'h400, 8'h81, 16'h0000},
        {1'b1, 2'd0, 12'h001, 8'h05, 16'h9999},
        {1'b0, 2'd0, 12'h001, 8'h05, 16'h0000}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic vld [2];
    logic req_we = 1'b0;
    logic [21:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic rdy [2], rv [2], cke [2], csn [2], rasn [2], casn [2], wen [2], oe [2];
    logic [15:0] rd [2], dqo [2], dqi [2];
    logic [1:0] ba [2], dqm [2];
    logic [11:0] sa [2];
    int errs [2], refs [2], init_at [2];
    int n_chk = 0, n_bad = 0;
    logic [15:0] ref_mem [2][int];

    always #2 clk = ~clk;

    sdram_cmd_ctrl #(.CAS_LAT(2), .POWERUP_CYC(PWR), .T_RCD(T_RCD), .T_RP(T_RP), .T_RFC(T_RFC),
                     .T_MRD(T_MRD), .T_WR(T_WR), .REF_CYC(REF_CYC)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(vld[0]), .req_we(req_we), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_ready(rdy[0]), .rd_valid(rv[0]), .rd_data(rd[0]),
        .sd_cke(cke[0]), .sd_cs_n(csn[0]), .sd_ras_n(rasn[0]), .sd_cas_n(casn[0]), .sd_we_n(wen[0]),
        .sd_ba(ba[0]), .sd_addr(sa[0]), .sd_dqm(dqm[0]), .sd_dq_out(dqo[0]), .sd_dq_oe(oe[0]),
        .sd_dq_in(dqi[0]));

    sdram_cmd_ctrl #(.CAS_LAT(3), .POWERUP_CYC(PWR), .T_RCD(T_RCD), .T_RP(T_RP), .T_RFC(T_RFC),
                     .T_MRD(T_MRD), .T_WR(T_WR), .REF_CYC(REF_CYC)) u1 (
        .clk(clk), .rst_n(rst_n), .req_valid(vld[1]), .req_we(req_we), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_ready(rdy[1]), .rd_valid(rv[1]), .rd_data(rd[1]),
        .sd_cke(cke[1]), .sd_cs_n(csn[1]), .sd_ras_n(rasn[1]), .sd_cas_n(casn[1]), .sd_we_n(wen[1]),
        .sd_ba(ba[1]), .sd_addr(sa[1]), .sd_dqm(dqm[1]), .sd_dq_out(dqo[1]), .sd_dq_oe(oe[1]),
        .sd_dq_in(dqi[1]));

    sdr_bus_model #(.CL(2), .PWR(PWR), .T_RCD(T_RCD), .T_RP(T_RP), .T_RFC(T_RFC), .T_MRD(T_MRD),
                    .T_WR(T_WR), .REF_CYC(REF_CYC)) m0 (
        .clk(clk), .rst_n(rst_n), .cs_n(csn[0]), .ras_n(rasn[0]), .cas_n(casn[0]), .we_n(wen[0]),
        .ba(ba[0]), .a(sa[0]), .dq_out(dqo[0]), .dq_oe(oe[0]), .dq_in(dqi[0]),
        .errs(errs[0]), .refs(refs[0]), .init_at(init_at[0]));

    sdr_bus_model #(.CL(3), .PWR(PWR), .T_RCD(T_RCD), .T_RP(T_RP), .T_RFC(T_RFC), .T_MRD(T_MRD),
                    .T_WR(T_WR), .REF_CYC(REF_CYC)) m1 (
        .clk(clk), .rst_n(rst_n), .cs_n(csn[1]), .ras_n(rasn[1]), .cas_n(casn[1]), .we_n(wen[1]),
        .ba(ba[1]), .a(sa[1]), .dq_out(dqo[1]), .dq_oe(oe[1]), .dq_in(dqi[1]),
        .errs(errs[1]), .refs(refs[1]), .init_at(init_at[1]));

    task automatic chk(input string r, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", r, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    // one request on controller d; returns read data and strobe latency
    task automatic access(input int d, input logic w, input logic [21:0] ad, input logic [15:0] wd,
                          output logic [15:0] got, output int lat, output int width);
        @(negedge clk);
        req_we = w; req_addr = ad; req_wdata = wd; vld[d] = 1'b1;
        while (!rdy[d]) @(negedge clk);
        @(negedge clk);
        vld[d] = 1'b0;
        lat = 0; width = 0; got = '0;
        if (!w) begin
            while (!rv[d] && lat < 60) begin @(negedge clk); lat++; end
            got = rd[d];
            while (rv[d] && width < 5) begin @(negedge clk); width++; end
        end else begin
            ref_mem[d][int'(ad)] = wd;
        end
    endtask

    initial begin
        #(4 * 150000);
        n_bad++;
        $display("FAIL watchdog: run did not end, actual hung expected done");
        finish_run();
    end

    initial begin
        logic [15:0] got;
        int lat, width, r0;
        vld[0] = 1'b0; vld[1] = 1'b0;
        repeat (3) @(negedge clk);
        // R1 reset state
        for (int d = 0; d < 2; d++) begin
            chk("R1", "command pins in reset", int'({csn[d], rasn[d], casn[d], wen[d]}), 7);
            chk("R1", "cke/ready/valid/oe in reset", int'({cke[d], rdy[d], rv[d], oe[d]}), 8);
        end
        rst_n = 1'b1;
        repeat (PWR / 2) @(negedge clk);
        for (int d = 0; d < 2; d++)
            chk("R1", "NOP during power-up wait", int'({csn[d], rasn[d], casn[d], wen[d], rdy[d]}), 14);
        repeat (PWR + T_RP + 2 * T_RFC + T_MRD) @(negedge clk);
        for (int d = 0; d < 2; d++) begin
            chk("R3", "LOAD MODE cycle", init_at[d], PWR + T_RP + 2 * T_RFC);
            chk("R5", "ready after start-up", int'(rdy[d]), 1);
        end

        // vector walk on both CAS latencies
        for (int d = 0; d < 2; d++) begin
            for (int v = 0; v < NV; v++) begin
                logic [21:0] ad;
                logic [15:0] expd;
                ad = VECS[v][37:16];
                access(d, VECS[v][38], ad, VECS[v][15:0], got, lat, width);
                if (!VECS[v][38]) begin
                    expd = ref_mem[d].exists(int'(ad)) ? ref_mem[d][int'(ad)] : 16'h0000;
                    chk("R9", $sformatf("read data ctl%0d vec%0d", d, v), int'(got), int'(expd));
                    chk("R9", $sformatf("read latency ctl%0d vec%0d", d, v), lat, 1 + T_RCD + 2 + d);
                    chk("R9", $sformatf("strobe width ctl%0d vec%0d", d, v), width, 1);
                end
            end
        end

        // R10 idle refresh rate
        r0 = refs[0];
        repeat (4 * REF_CYC) @(negedge clk);
        chk("R10", "refreshes while idle", int'((refs[0] - r0) >= 3 && (refs[0] - r0) <= 5), 1);

        // R10 priority under a continuous request stream
        r0 = refs[1];
        for (int k = 0; k < 60; k++)
            access(1, 1'b1, {2'(k), 12'(k * 7), 8'(k)}, 16'(k * 3 + 1), got, lat, width);
        chk("R10", "refreshes during request stream", int'(refs[1] - r0 >= 2), 1);
        access(1, 1'b0, {2'd3, 12'(59 * 7), 8'd59}, 16'h0, got, lat, width);
        chk("R9", "read back after stream", int'(got), 59 * 3 + 1);

        repeat (10) @(negedge clk);
        for (int d = 0; d < 2; d++) begin
            chk("R8", $sformatf("bus model violations ctl%0d", d), errs[d], 0);
            chk("R7", $sformatf("byte masks ctl%0d", d), int'(dqm[d]), 0);
        end
        finish_run();
    end
endmodule